// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks the clock that drives one clock domain from a set of free-running input clocks. Software writes a 3-bit source code into a small control register; the block then moves the domain clock to the new source in the background. Each source has its own gate. The gate of the old source closes while that source is low. Only after that closure is confirmed back in the register clock domain does the new source's gate open, again while the new source is low. A busy bit in the same register reads 1 for as long as the move is in progress. Software polls that bit until it clears before relying on the new clock.

Codes that name no source are rejected. So are writes that arrive while a move is still running. A write naming the source already in use finishes at once. In each of these cases the register keeps its contents and busy stays low. The register port is a plain write-enable / write-data / read-data interface in the register clock domain. It carries no stream traffic, so it has no valid/ready handshake. All pins are plain control and status.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the select field reads 0, busy reads 0, and the output clock follows the main oscillator (code 0).
- R2: Register layout: bits [2:0] hold the select code, bit 3 is busy, and all higher bits read 0. The codes are 0 main oscillator, 1 low-speed real-time oscillator, 2 PLL1, 3 PLL2, 4 PLL3.
- R3: A write of code 5, 6 or 7 is ignored. The select field is unchanged, busy stays 0, and the output keeps its current source.
- R4: A write of a valid code that differs from the current one changes the select field to the new code and sets busy, both visible in the first register-clock cycle after the write.
- R5: Any write made while busy is 1 is ignored. The select field keeps the code of the move in progress.
- R6: Busy clears within 300 register-clock cycles for the bench clocks. While busy is 0, the output clock equals the source named by the select field exactly.
- R7: A write of the code already in use leaves busy at 0 and the select field unchanged.
- R8: The output never shows a high or low pulse shorter than the shorter half period of the two sources involved. At no time is more than one source gate open.
- R9: Once busy has cleared, it stays 0 until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| src_clk | input | NUM_SRC | Candidate source clocks, bit i is the source with code i |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | RDATA_W | Register write data; bits [2:0] are the requested code |
| cfg_rdata | output | RDATA_W | Register read data: select in [2:0], busy in bit 3 |
| clk_out | output | 1 | Gated domain clock |

## Verification
A wrong control state shows in the register read-back in the very next register cycle: a select code that moves when it should hold, a busy bit that rises for a rejected write, or a busy bit that never falls. A gate left open, or one opened too early, shows directly at clk_out. The output then disagrees with the named source within one source period after busy clears, or a runt pulse a fraction of a source half period wide appears during the move. The bench samples clk_out at half-nanosecond steps placed away from every clock edge, so both kinds of fault surface within nanoseconds.

// File: rtl/clk_sel_pkg.sv
`timescale 1ns/1ps
package clk_sel_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned BUSY_POS = 3;
  localparam int unsigned SYNC_N   = 2;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_DROP,
    SW_RAISE
  } sw_state_e;
endpackage

// File: rtl/clk_sel_sync.sv
`timescale 1ns/1ps
module clk_sel_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_sel_lane.sv
`timescale 1ns/1ps
module clk_sel_lane
  import clk_sel_pkg::*;
#(
  parameter bit RST_ON = 1'b0
) (
  input  logic src_clk,
  input  logic reg_clk,
  input  logic rst_n,
  input  logic req_i,
  output logic gate_o,
  output logic ack_o,
  output logic clk_o
);
  logic req_s;
  logic gate_q;

  // request crosses into the source domain
  clk_sel_sync #(.STAGES(SYNC_N), .RST_VAL(RST_ON)) u_req_sync (
    .clk  (src_clk),
    .rst_n(rst_n),
    .d    (req_i),
    .q    (req_s)
  );

  // gate changes only on the falling edge, while the source is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_q <= RST_ON;
    else        gate_q <= req_s;
  end

  // gate state returns to the register domain as acknowledge
  clk_sel_sync #(.STAGES(SYNC_N), .RST_VAL(RST_ON)) u_ack_sync (
    .clk  (reg_clk),
    .rst_n(rst_n),
    .d    (gate_q),
    .q    (ack_o)
  );

  assign gate_o = gate_q;
  assign clk_o  = src_clk & gate_q;
endmodule

// File: rtl/clk_sel_ctrl.sv
`timescale 1ns/1ps
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 5,
  parameter int unsigned RESET_SEL = 0
) (
  input  logic               reg_clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_code,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               busy_o
);
  localparam logic [NUM_SRC-1:0] ONE_HOT_RST = NUM_SRC'(1) << RESET_SEL;

  sw_state_e          state_q;
  logic [SEL_W-1:0]   sel_q;
  logic [NUM_SRC-1:0] req_q;
  logic               code_ok;
  logic               accept;

  always_comb begin
    code_ok = int'(wr_code) < int'(NUM_SRC);
    accept  = wr_en && (state_q == SW_IDLE) && code_ok && (wr_code != sel_q);
  end

  always_ff @(posedge reg_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      sel_q   <= SEL_W'(RESET_SEL);
      req_q   <= ONE_HOT_RST;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (accept) begin
            sel_q   <= wr_code;
            req_q   <= '0;
            state_q <= SW_DROP;
          end
        end
        SW_DROP: begin
          if (ack_i == '0) begin
            req_q   <= NUM_SRC'(1) << sel_q;
            state_q <= SW_RAISE;
          end
        end
        SW_RAISE: begin
          if (ack_i[sel_q]) state_q <= SW_IDLE;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign sel_o  = sel_q;
  assign busy_o = (state_q != SW_IDLE);
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch
  import clk_sel_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 5,
  parameter int unsigned RDATA_W   = 8,
  parameter int unsigned RESET_SEL = 0
) (
  input  logic               reg_clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               cfg_we,
  input  logic [RDATA_W-1:0] cfg_wdata,
  output logic [RDATA_W-1:0] cfg_rdata,
  output logic               clk_out
);
  logic [NUM_SRC-1:0] lane_req;
  logic [NUM_SRC-1:0] lane_ack;
  logic [NUM_SRC-1:0] lane_gate;
  logic [NUM_SRC-1:0] lane_clk;
  logic [SEL_W-1:0]   sel;
  logic               busy;
  logic               unused_wdata;

  assign unused_wdata = ^cfg_wdata[RDATA_W-1:SEL_W];

  clk_sel_ctrl #(.NUM_SRC(NUM_SRC), .RESET_SEL(RESET_SEL)) u_ctrl (
    .reg_clk(reg_clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_code(cfg_wdata[SEL_W-1:0]),
    .ack_i  (lane_ack),
    .req_o  (lane_req),
    .sel_o  (sel),
    .busy_o (busy)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    clk_sel_lane #(.RST_ON(i == RESET_SEL)) u_lane (
      .src_clk(src_clk[i]),
      .reg_clk(reg_clk),
      .rst_n  (rst_n),
      .req_i  (lane_req[i]),
      .gate_o (lane_gate[i]),
      .ack_o  (lane_ack[i]),
      .clk_o  (lane_clk[i])
    );
  end

  assign clk_out   = |lane_clk;
  assign cfg_rdata = RDATA_W'({busy, sel});
endmodule

// File: rtl/clk_src_switch_chk.sv
`timescale 1ns/1ps
module clk_src_switch_chk #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned RDATA_W = 8
) (
  input logic               reg_clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [RDATA_W-1:0] cfg_wdata,
  input logic [RDATA_W-1:0] cfg_rdata,
  input logic [NUM_SRC-1:0] lane_gate
);
  logic [2:0] wcode;
  logic [2:0] rsel;
  logic       rbusy;

  assign wcode = cfg_wdata[2:0];
  assign rsel  = cfg_rdata[2:0];
  assign rbusy = cfg_rdata[3];

  a_r3_invalid_ignored: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (cfg_we && !rbusy && int'(wcode) >= int'(NUM_SRC)) |=> (!rbusy && rsel == $past(rsel)));

  a_r4_accept_sets_busy: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (cfg_we && !rbusy && int'(wcode) < int'(NUM_SRC) && wcode != rsel)
      |=> (rbusy && rsel == $past(wcode)));

  a_r5_busy_write_ignored: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (cfg_we && rbusy) |=> (rsel == $past(rsel)));

  a_r7_same_code_no_busy: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (cfg_we && !rbusy && wcode == rsel) |=> !rbusy);

  a_r8_one_gate: assert property (@(posedge reg_clk) disable iff (!rst_n)
    $onehot0(lane_gate));

  a_r6_idle_gate_matches: assert property (@(posedge reg_clk) disable iff (!rst_n)
    !rbusy |-> (lane_gate == (NUM_SRC'(1) << rsel)));
endmodule

bind clk_src_switch clk_src_switch_chk #(.NUM_SRC(NUM_SRC), .RDATA_W(RDATA_W)) u_chk (
  .reg_clk  (reg_clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .lane_gate(lane_gate)
);

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;
  localparam int NSRC = 5;
  localparam int RW   = 8;

  logic            reg_clk = 1'b0;
  logic            rst_n   = 1'b0;
  logic            c_osc = 0, c_rtc = 0, c_p1 = 0, c_p2 = 0, c_p3 = 0;
  logic [NSRC-1:0] src_clk;
  logic            cfg_we  = 1'b0;
  logic [RW-1:0]   cfg_wdata = '0;
  logic [RW-1:0]   cfg_rdata;
  logic            clk_out;

  int checks = 0;
  int errors = 0;

  assign src_clk = {c_p3, c_p2, c_p1, c_rtc, c_osc};

  clk_src_switch i_clk_src_switch (
    .reg_clk  (reg_clk),
    .rst_n    (rst_n),
    .src_clk  (src_clk),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .clk_out  (clk_out)
  );

  // 125 MHz register clock; sources with integer half periods
  initial forever #4 reg_clk = ~reg_clk;
  initial forever #5 c_osc = ~c_osc;
  initial begin #1; forever #47 c_rtc = ~c_rtc; end
  initial begin #2; forever #3 c_p1 = ~c_p1; end
  initial begin #1; forever #4 c_p2 = ~c_p2; end
  initial forever #2 c_p3 = ~c_p3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model, compared every cycle
  int exp_sel  = 0;
  bit m_busy   = 0;
  bit m_first  = 0;
  int m_wait   = 0;
  bit timeout_seen = 0;

  always begin
    @(posedge reg_clk);
    if (rst_n) begin
      if (cfg_we && !m_busy) begin
        if (int'(cfg_wdata[2:0]) < NSRC && int'(cfg_wdata[2:0]) != exp_sel) begin
          exp_sel = int'(cfg_wdata[2:0]);
          m_busy  = 1;
          m_first = 1;
          m_wait  = 0;
        end
      end
      #1;
      chk(int'(cfg_rdata[2:0]) == exp_sel, "R2/R3/R5 select field", int'(cfg_rdata[2:0]), exp_sel);
      chk(cfg_rdata[RW-1:4] == '0, "R2 upper bits zero", int'(cfg_rdata[RW-1:4]), 0);
      if (m_first) begin
        chk(cfg_rdata[3] == 1'b1, "R4 busy after accepted write", int'(cfg_rdata[3]), 1);
        m_first = 0;
      end else if (m_busy) begin
        if (!cfg_rdata[3]) m_busy = 0;
        else begin
          m_wait++;
          if (m_wait > 300 && !timeout_seen) begin
            timeout_seen = 1;
            chk(1'b0, "R6 busy timeout", m_wait, 300);
          end
        end
      end else begin
        chk(cfg_rdata[3] == 1'b0, "R9/R3/R7 busy stays low", int'(cfg_rdata[3]), 0);
      end
    end
  end

  // ---------------- runt pulse monitor (R8), samples away from edges
  int runts = 0;
  initial begin
    int  run   = 0;
    bit  armed = 0;
    logic last = 1'bx;
    #0.25;
    forever begin
      #0.5;
      if (rst_n) begin
        if (clk_out === last) run++;
        else begin
          if (armed && run < 4) runts++;
          armed = 1;
          run   = 1;
          last  = clk_out;
        end
      end
    end
  end

  task automatic wr(input int code);
    @(posedge reg_clk); #2;
    cfg_we    = 1'b1;
    cfg_wdata = RW'(code);
    @(posedge reg_clk); #2;
    cfg_we    = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(posedge reg_clk); #1;
      if (!cfg_rdata[3]) break;
    end
  endtask

  task automatic follow(input int code, input string tag);
    int bad = 0;
    @(posedge reg_clk); #1; #0.25;
    for (int k = 0; k < 400; k++) begin
      if (clk_out !== src_clk[code]) bad++;
      #0.5;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge reg_clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40 rst_n = 1'b1;
    @(posedge reg_clk); #1;
    chk(cfg_rdata == '0, "R1 reset read-back", int'(cfg_rdata), 0);
    follow(0, "R1 output follows main oscillator");

    wr(2); wait_idle();
    follow(2, "R6 output follows PLL1");

    wr(1); wr(4); wait_idle();                  // second write ignored: R5
    chk(int'(cfg_rdata[2:0]) == 1, "R5 write during busy ignored", int'(cfg_rdata[2:0]), 1);
    follow(1, "R6 output follows real-time oscillator");

    wr(6); repeat (3) @(posedge reg_clk);
    follow(1, "R3 invalid code keeps source");
    wr(1); repeat (3) @(posedge reg_clk);
    follow(1, "R7 same code keeps source");

    wr(4); wait_idle(); follow(4, "R6 output follows PLL3");
    wr(5); wr(7); repeat (3) @(posedge reg_clk);
    follow(4, "R3 invalid codes keep PLL3");
    wr(3); wait_idle(); follow(3, "R6 output follows PLL2");
    wr(0); wait_idle(); follow(0, "R6 output back on main oscillator");
    wr(1); wait_idle(); wr(3); wait_idle(); follow(3, "R6 real-time to PLL2");

    chk(runts == 0, "R8 no runt pulses", runts, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule